// File: doc/BRIEF.md
# NAND Page De-Interleaver

This block takes one raw flash page as a byte stream and puts it back out in the order software wants. On the flash, each sector is stored as its data bytes, then its free bytes (the per-sector user/metadata area), then its parity bytes. The free bytes and the parity bytes together fill the per-sector spare area. In linear mode the block sends out every sector's data first, then the free bytes of all sectors, packed in sector order. Parity bytes are dropped.

In linear mode the block can also exchange one byte pair. This keeps the bad-block marker where a boot loader looks for it. The pair is the data-area byte at position `page - (sectors-1)*spare` and the first free byte of the last sector, at position `page + (sectors-1)*free`. In raw mode the page passes through untouched, in its original order and at full length.

The whole page is stored in an internal buffer before any byte is sent out. The state machine has three states:
- `ST_IDLE` samples the configuration on every cycle. It moves to `ST_LOAD` on the first `in_valid`.
- `ST_LOAD` accepts bytes. It moves to `ST_EMIT` on the handshake of the last spare byte of the last sector.
- `ST_EMIT` presents the buffer in order. It moves back to `ST_IDLE` on the handshake of the last output byte, and that handshake raises `done`.

Top module: `page_deinterleave`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `done` are all 0.
- R2: The configuration inputs are sampled only in `ST_IDLE`. Changing them while a page is being loaded or sent has no effect on that page's output.
- R3: `in_ready` and `out_valid` are never high together. No output byte is offered before the last input byte of the page has been accepted.
- R4: In linear mode (`cfg_linear`=1) the output is `sectors*sect` data bytes in sector order, followed by `sectors*free` free bytes in sector order. The length is `sectors*(sect+free)`.
- R5: In linear mode the `spare-free` parity bytes that follow each sector's free bytes never appear at the output.
- R6: With `cfg_linear`=1, `cfg_bbm_swap`=1 and `cfg_sectors`>1, the output byte at `sectors*sect - (sectors-1)*spare` and the output byte at `sectors*sect + (sectors-1)*free` are exchanged.
- R7: If `cfg_sectors`=1 or `cfg_bbm_swap`=0, no exchange is made.
- R8: In raw mode (`cfg_linear`=0) all `sectors*(sect+spare)` bytes come out in input order. `cfg_bbm_swap` has no effect in this mode.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the last output handshake. The block then accepts a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sect_bytes | input | SW | Data bytes per sector |
| cfg_spare_bytes | input | PW | Spare bytes per sector (free + parity) |
| cfg_free_bytes | input | PW | Free bytes per sector |
| cfg_sectors | input | NW | Sectors per page |
| cfg_linear | input | 1 | 1 = linear reorder, 0 = raw pass-through |
| cfg_bbm_swap | input | 1 | Enable the marker-byte exchange |
| in_data | input | 8 | Raw page byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| out_data | output | 8 | Reordered page byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| done | output | 1 | Page complete pulse |

## Verification
The assertions assume a well-formed configuration:
- `cfg_sectors` is at least 1.
- `cfg_free_bytes` is at most `cfg_spare_bytes`.
- The sector count and sector size fit the parameter maxima.
- `(sectors-1)*spare` is smaller than `sectors*sect`, so the exchange position lies inside the data area.

The assertions also assume the configuration is stable during the `ST_IDLE` cycle in which `in_valid` first rises. The stimulus meets these conditions by setting every configuration field before the first byte of a page and by choosing sizes that satisfy the inequalities above. The only exception is the deliberate mid-page change, which is made while the block is no longer in `ST_IDLE`.

// File: rtl/pdi_pkg.sv
package pdi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } pdi_state_e;
endpackage

// File: rtl/pdi_addr_map.sv
// Maps (sector, column) of an incoming raw byte to its buffer slot.
module pdi_addr_map #(
    parameter int SW = 7,
    parameter int PW = 5,
    parameter int NW = 3,
    parameter int CW = 7,
    parameter int AW = 9
) (
    input  logic [NW-1:0] sec_idx,
    input  logic [CW-1:0] col,
    input  logic [SW-1:0] sect,
    input  logic [PW-1:0] spare,
    input  logic [PW-1:0] free,
    input  logic [NW-1:0] nsect,
    input  logic          linear,
    input  logic          swap_en,
    output logic [AW-1:0] addr,
    output logic          keep
);
    logic [AW-1:0] a_sec, a_col, a_sect, a_spare, a_free, a_n;
    logic [AW-1:0] page_len, pos_data, pos_free, base;
    logic          swap_on;

    always_comb begin
        a_sec    = AW'(sec_idx);
        a_col    = AW'(col);
        a_sect   = AW'(sect);
        a_spare  = AW'(spare);
        a_free   = AW'(free);
        a_n      = AW'(nsect);
        page_len = a_n * a_sect;
        pos_data = page_len - (a_n - 1'b1) * a_spare;
        pos_free = page_len + (a_n - 1'b1) * a_free;
        swap_on  = linear && swap_en && (nsect > NW'(1));
        keep     = 1'b1;
        if (!linear) begin
            base = a_sec * (a_sect + a_spare) + a_col;
        end else if (a_col < a_sect) begin
            base = a_sec * a_sect + a_col;
        end else if (a_col < a_sect + a_free) begin
            base = page_len + a_sec * a_free + (a_col - a_sect);
        end else begin
            base = '0;
            keep = 1'b0;
        end
        if (swap_on && base == pos_data)      addr = pos_free;
        else if (swap_on && base == pos_free) addr = pos_data;
        else                                  addr = base;
    end
endmodule

// File: rtl/pdi_page_buf.sv
module pdi_page_buf #(
    parameter int DEPTH = 320,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/page_deinterleave.sv
module page_deinterleave #(
    parameter int MAX_SECT  = 64,
    parameter int MAX_SPARE = 16,
    parameter int MAX_NSECT = 4,
    localparam int SW    = $clog2(MAX_SECT + 1),
    localparam int PW    = $clog2(MAX_SPARE + 1),
    localparam int NW    = $clog2(MAX_NSECT + 1),
    localparam int CW    = $clog2(MAX_SECT + MAX_SPARE + 1),
    localparam int DEPTH = MAX_NSECT * (MAX_SECT + MAX_SPARE),
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cfg_sect_bytes,
    input  logic [PW-1:0] cfg_spare_bytes,
    input  logic [PW-1:0] cfg_free_bytes,
    input  logic [NW-1:0] cfg_sectors,
    input  logic          cfg_linear,
    input  logic          cfg_bbm_swap,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [7:0]    out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          done
);
    import pdi_pkg::*;

    pdi_state_e    st, st_nxt;
    logic [SW-1:0] c_sect;
    logic [PW-1:0] c_spare, c_free;
    logic [NW-1:0] c_n;
    logic          c_lin, c_swap;
    logic [CW-1:0] col;
    logic [NW-1:0] sec;
    logic [AW-1:0] rd_ptr, out_len, map_addr;
    logic [CW-1:0] unit_len;
    logic          map_keep, last_in, last_out, wr_en, done_q;

    assign unit_len = CW'(c_sect) + CW'(c_spare);
    assign out_len  = c_lin ? AW'(c_n) * (AW'(c_sect) + AW'(c_free))
                            : AW'(c_n) * AW'(unit_len);
    assign last_in  = (col == unit_len - 1'b1) && (sec == c_n - 1'b1);
    assign last_out = (rd_ptr == out_len - 1'b1);

    pdi_addr_map #(.SW(SW), .PW(PW), .NW(NW), .CW(CW), .AW(AW)) u_map (
        .sec_idx(sec), .col(col), .sect(c_sect), .spare(c_spare),
        .free(c_free), .nsect(c_n), .linear(c_lin), .swap_en(c_swap),
        .addr(map_addr), .keep(map_keep)
    );

    pdi_page_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk), .we(wr_en), .waddr(map_addr), .wdata(in_data),
        .raddr(rd_ptr), .rdata(out_data)
    );

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (in_valid) st_nxt = ST_LOAD;
            ST_LOAD: if (in_valid && last_in) st_nxt = ST_EMIT;
            ST_EMIT: if (out_ready && last_out) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // outputs
    always_comb begin
        in_ready  = (st == ST_LOAD);
        out_valid = (st == ST_EMIT);
        wr_en     = in_ready && in_valid && map_keep;
        done      = done_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_sect <= '0; c_spare <= '0; c_free <= '0; c_n <= '0;
            c_lin  <= 1'b0; c_swap <= 1'b0;
            col    <= '0; sec <= '0; rd_ptr <= '0; done_q <= 1'b0;
        end else begin
            done_q <= (st == ST_EMIT) && out_ready && last_out;
            unique case (st)
                ST_IDLE: begin
                    c_sect <= cfg_sect_bytes;  c_spare <= cfg_spare_bytes;
                    c_free <= cfg_free_bytes;  c_n     <= cfg_sectors;
                    c_lin  <= cfg_linear;      c_swap  <= cfg_bbm_swap;
                    col    <= '0; sec <= '0; rd_ptr <= '0;
                end
                ST_LOAD: if (in_valid) begin
                    if (col == unit_len - 1'b1) begin
                        col <= '0;
                        sec <= sec + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_EMIT: if (out_ready) rd_ptr <= rd_ptr + 1'b1;
                default: ;
            endcase
        end
    end

    // checks
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_emit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid) && $past(out_ready));
    assert_map_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> map_addr < out_len);
endmodule

// File: tb/page_deinterleave_tb.sv
module page_deinterleave_tb;
    localparam int MAX_SECT = 64, MAX_SPARE = 16, MAX_NSECT = 4;
    localparam int SW = $clog2(MAX_SECT + 1);
    localparam int PW = $clog2(MAX_SPARE + 1);
    localparam int NW = $clog2(MAX_NSECT + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [SW-1:0] cfg_sect_bytes = '0;
    logic [PW-1:0] cfg_spare_bytes = '0, cfg_free_bytes = '0;
    logic [NW-1:0] cfg_sectors = '0;
    logic cfg_linear = 1'b0, cfg_bbm_swap = 1'b0;
    logic [7:0] in_data = '0, out_data;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, done;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    int pending_done = 0;
    bit loading = 1'b0, early_out = 1'b0, bp_mode = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;

    page_deinterleave #(.MAX_SECT(MAX_SECT), .MAX_SPARE(MAX_SPARE),
                        .MAX_NSECT(MAX_NSECT)) u_dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready <= bp_mode ? (cyc % 3 != 0) : 1'b1;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor
    initial begin
        bit hold = 1'b0;
        logic [7:0] held = '0;
        forever begin
            @(negedge clk);
            if (out_valid && (loading || in_ready)) early_out = 1'b1;
            if (pending_done == 1) begin
                check(done == 1'b1, "R10", int'(done), 1); pending_done = 2;
            end else if (pending_done == 2) begin
                check(done == 1'b0, "R10", int'(done), 0); pending_done = 0;
            end
            if (hold) begin
                check(out_valid && out_data == held, "R9", int'(out_data), int'(held));
                hold = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", int'(out_data), -1);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, int'(out_data), int'(e));
                    if (exp_q.size() == 0) pending_done = 1;
                end
            end else if (out_valid) begin
                hold = 1'b1; held = out_data;
            end
        end
    end

    task automatic send(logic [7:0] b);
        in_data = b; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // driver: builds raw page, pushes expected items, sends page
    task automatic run_page(int sect, int spare, int free, int n, bit lin,
                            bit swp, int seed, bit bp, bit scramble, string tag);
        logic [7:0] raw[$];
        logic [7:0] ex[$];
        int unit = sect + spare;
        bp_mode = bp;
        for (int k = 0; k < n * unit; k++) raw.push_back(8'((k * 13 + seed) ^ (k >> 3)));
        if (lin) begin
            for (int s = 0; s < n; s++)
                for (int c = 0; c < sect; c++) ex.push_back(raw[s * unit + c]);
            for (int s = 0; s < n; s++)
                for (int f = 0; f < free; f++) ex.push_back(raw[s * unit + sect + f]);
            if (swp && n > 1) begin
                int pa = n * sect - (n - 1) * spare;
                int pb = n * sect + (n - 1) * free;
                logic [7:0] t = ex[pa];
                ex[pa] = ex[pb]; ex[pb] = t;
            end
        end else begin
            foreach (raw[k]) ex.push_back(raw[k]);
        end
        foreach (ex[k]) begin exp_q.push_back(ex[k]); tag_q.push_back(tag); end
        cfg_sect_bytes = SW'(sect); cfg_spare_bytes = PW'(spare);
        cfg_free_bytes = PW'(free); cfg_sectors = NW'(n);
        cfg_linear = lin; cfg_bbm_swap = swp;
        early_out = 1'b0; loading = 1'b1;
        @(posedge clk); #1;
        foreach (raw[k]) begin
            if (scramble && k == raw.size() / 2) begin
                cfg_sect_bytes = SW'(8); cfg_spare_bytes = PW'(2);
                cfg_free_bytes = PW'(1); cfg_sectors = NW'(1);
                cfg_linear = ~lin; cfg_bbm_swap = ~swp;
            end
            send(raw[k]);
        end
        loading = 1'b0;
        wait (exp_q.size() == 0 && pending_done == 0);
        check(!early_out, "R3", int'(early_out), 0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!in_ready && !out_valid && !done, "R1",
              int'({in_ready, out_valid, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        // R4 R6: linear reorder with marker exchange, parity dropped (R5)
        run_page(16, 6, 2, 4, 1'b1, 1'b1, 5, 1'b0, 1'b0, "R6");
        // R7: exchange disabled, backpressure exercises R9
        run_page(16, 6, 2, 4, 1'b1, 1'b0, 77, 1'b1, 1'b0, "R7");
        // R7: single sector, exchange requested but skipped
        run_page(20, 8, 3, 1, 1'b1, 1'b1, 31, 1'b0, 1'b0, "R7");
        // R8: raw pass-through, swap flag ignored
        run_page(8, 4, 2, 3, 1'b0, 1'b1, 9, 1'b1, 1'b0, "R8");
        // R2: configuration changed mid-page must not matter
        run_page(32, 16, 8, 2, 1'b1, 1'b1, 200, 1'b1, 1'b1, "R2");
        // R4: free area fills the whole spare, no parity
        run_page(12, 4, 4, 3, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R4");
        // R5: maximum parity share per sector
        run_page(64, 16, 1, 4, 1'b1, 1'b0, 111, 1'b1, 1'b0, "R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule